// File: doc/BRIEF.md
# MDIO Management Master with Legacy and Extended Framing

This block is the bus-side master for the two-wire management interface that controls Ethernet PHYs. It derives the management clock from the system clock and serialises one register access at a time onto a shared bidirectional data line. The data line is presented as three pins: a data output, an output enable and a data input. A pad or tristate buffer outside the block combines them.

A host presents a request for one system clock. The request carries a read/write flag, a 5-bit port address, a 32-bit register field and 16 bits of write data. Bit 31 of the register field chooses between two framings.

- Legacy framing uses bits 4:0 of the register field as the register number and sends a single frame.
- Extended framing splits bits 20:0 of the register field into a 5-bit device code and a 16-bit register offset. It sends two frames: an address frame that loads the offset, then the read or write frame.

Both kinds of access can share one bus. At completion the block pulses `done`; for a read it also presents the returned data and a turnaround error flag.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and whenever no access is in progress, `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: Each half-period of `mdc` lasts `mdc_half` system clocks, with 0 treated as 1; the value is latched when a request is accepted. `mdio_o` and `mdio_oe` change only together with a falling `mdc` edge, and `mdio_i` is sampled at the rising edge.
- R3: Every frame begins with 32 bits of 1 driven by the master (`mdio_oe` high).
- R4: A legacy frame (`req_addr[31]`=0) sends start bits 0,1, then the opcode (read 1,0; write 0,1), then the port address and `req_addr[4:0]`, each 5 bits MSB first.
- R5: An extended access (`req_addr[31]`=1) first sends an address frame made of the following fields, in order:
  - start 0,0 and opcode 0,0;
  - the port address and the device code `req_addr[20:16]`;
  - turnaround 1,0 and the offset `req_addr[15:0]`, MSB first;
  - one clock with the line released.

  It then sends the data frame with start 0,0, opcode 0,1 (write) or 1,1 (read), and the same port and device code. An extended read takes 130 `mdc` cycles and an extended write takes 129.
- R6: A write frame drives turnaround 1,0 followed by `req_wdata` MSB first. It ends after its 64th bit, with no released clock.
- R7: A read frame releases the line (`mdio_oe` low) from the first turnaround bit onward. It samples 16 data bits MSB first into `rd_data`, then clocks one more released cycle, so a legacy read takes 65 `mdc` cycles.
- R8: `rd_err` is 1 after a read whose second turnaround bit was sampled high, and 0 after a read where it was low and after any write.
- R9: `busy` rises on the clock after an accepted request and stays high through the last bit of the final frame. `done` is a one-clock pulse on the cycle in which `busy` falls. A request presented while `busy` is high is ignored and does not change the frame in progress.
- R10: `mdio_oe` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 5 | Port address |
| req_addr | input | 32 | Register field; bit 31 selects extended framing |
| req_wdata | input | 16 | Write data |
| mdc_half | input | DIV_W | System clocks per `mdc` half-period (0 acts as 1) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| rd_err | output | 1 | Turnaround error of the last access |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A PHY model in the bench records every bit at rising `mdc` and answers reads. Each frame is compared bit by bit, enable included, against an independently built image. That comparison catches a design that sends legacy start or opcode codes in an extended frame, or that omits the released clock after the address frame (the data frame would then start one bit early). It also catches one that keeps driving through a read turnaround, or that adds a released clock after a write. Zero data, all-ones data and maximal port and device codes expose bit-order and field-swap errors. A `mdc_half` of 0 exposes a divider that stalls. A request injected mid-frame would corrupt the frame or add a second `done` in a design that failed to ignore it. A PHY that leaves the turnaround high must raise `rd_err`.

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int DIV_W   = 8,
  parameter int EXT_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [4:0]       req_port,
  input  logic [31:0]      req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [DIV_W-1:0] mdc_half,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             rd_err,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam int PRE_LEN  = 32;
  localparam int ST_POS   = PRE_LEN;
  localparam int OP_POS   = ST_POS + 2;
  localparam int PORT_POS = OP_POS + 2;
  localparam int FLD_POS  = PORT_POS + 5;
  localparam int TA_POS   = FLD_POS + 5;
  localparam int DAT_POS  = TA_POS + 2;
  localparam int END_POS  = DAT_POS + 16;

  logic             busy_q, done_q, mdc_q, ext_q, wr_q, ph_q, err_q, rerr_q;
  logic [6:0]       bit_q;
  logic [DIV_W-1:0] cnt_q, half_q;
  logic [4:0]       port_q, fld_q;
  logic [15:0]      off_q, wd_q, shf_q, rdat_q;

  logic        is_addr, is_rd, tick, d_bit, d_oe;
  logic [1:0]  op;
  logic [15:0] payload;
  logic [6:0]  last_bit, pidx, fidx, didx;

  assign is_addr  = ext_q & ~ph_q;
  assign is_rd    = ~wr_q & ~is_addr;
  assign op       = is_addr ? 2'b00 : (wr_q ? 2'b01 : (ext_q ? 2'b11 : 2'b10));
  assign payload  = is_addr ? off_q : wd_q;
  assign last_bit = (is_rd | is_addr) ? 7'(END_POS) : 7'(END_POS - 1);
  assign tick     = busy_q && (cnt_q == half_q - 1'b1);
  assign pidx     = 7'(FLD_POS - 1) - bit_q;
  assign fidx     = 7'(TA_POS - 1) - bit_q;
  assign didx     = 7'(END_POS - 1) - bit_q;

  always_comb begin
    d_bit = 1'b0;
    d_oe  = 1'b1;
    if (bit_q < 7'(ST_POS))          d_bit = 1'b1;
    else if (bit_q == 7'(ST_POS))    d_bit = 1'b0;
    else if (bit_q == 7'(ST_POS+1))  d_bit = ~ext_q;
    else if (bit_q == 7'(OP_POS))    d_bit = op[1];
    else if (bit_q == 7'(OP_POS+1))  d_bit = op[0];
    else if (bit_q < 7'(FLD_POS))    d_bit = port_q[pidx[2:0]];
    else if (bit_q < 7'(TA_POS))     d_bit = fld_q[fidx[2:0]];
    else if (bit_q == 7'(TA_POS)) begin
      d_bit = 1'b1;
      d_oe  = ~is_rd;
    end
    else if (bit_q == 7'(TA_POS+1))  d_oe = ~is_rd;
    else if (bit_q < 7'(END_POS)) begin
      d_bit = payload[didx[3:0]];
      d_oe  = ~is_rd;
    end
    else                             d_oe = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; mdc_q <= 1'b0;
      ext_q  <= 1'b0; wr_q   <= 1'b0; ph_q  <= 1'b0;
      err_q  <= 1'b0; rerr_q <= 1'b0;
      bit_q  <= '0;   cnt_q  <= '0;   half_q <= DIV_W'(1);
      port_q <= '0;   fld_q  <= '0;
      off_q  <= '0;   wd_q   <= '0;   shf_q <= '0; rdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          ext_q  <= req_addr[EXT_BIT];
          ph_q   <= ~req_addr[EXT_BIT];
          wr_q   <= req_write;
          port_q <= req_port;
          fld_q  <= req_addr[EXT_BIT] ? req_addr[20:16] : req_addr[4:0];
          off_q  <= req_addr[15:0];
          wd_q   <= req_wdata;
          half_q <= (mdc_half == '0) ? DIV_W'(1) : mdc_half;
          cnt_q  <= '0;
          bit_q  <= '0;
          mdc_q  <= 1'b0;
          err_q  <= 1'b0;
          shf_q  <= '0;
        end
      end else if (tick) begin
        cnt_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (is_rd && bit_q == 7'(TA_POS+1)) err_q <= mdio_i;
          if (is_rd && bit_q >= 7'(DAT_POS) && bit_q < 7'(END_POS))
            shf_q <= {shf_q[14:0], mdio_i};
        end else begin
          if (bit_q != last_bit) bit_q <= bit_q + 7'd1;
          else if (is_addr) begin
            ph_q  <= 1'b1;
            bit_q <= '0;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (is_rd) begin
              rdat_q <= shf_q;
              rerr_q <= err_q;
            end else rerr_q <= 1'b0;
          end
        end
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign rd_err  = rerr_q;
  assign mdc     = mdc_q;
  assign mdio_oe = busy_q & d_oe;
  assign mdio_o  = busy_q & d_oe & d_bit;

endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);

  assert_idle_mdc_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_oe_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_hold_while_mdc_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_accept_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind mdio_master mdio_master_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_port = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  mdc_half = 8'd1;
  logic        busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_addr(req_addr), .req_wdata(req_wdata),
    .mdc_half(mdc_half), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // {wr, ext, port, dev, reg/offset, wdata, rdata, half}
  localparam int NV = 8;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'h01, 5'h00, 16'h0004, 16'hA5C3, 16'h0000, 8'd2},
    {1'b0, 1'b0, 5'h1F, 5'h00, 16'h001F, 16'h0000, 16'h1234, 8'd1},
    {1'b1, 1'b1, 5'h03, 5'h01, 16'hBEEF, 16'h0F0F, 16'h0000, 8'd3},
    {1'b0, 1'b1, 5'h11, 5'h1E, 16'h0000, 16'h0000, 16'h8001, 8'd2},
    {1'b0, 1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 16'hFFFF, 8'd0},
    {1'b0, 1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0000, 16'h0000, 8'd1},
    {1'b1, 1'b1, 5'h1F, 5'h1F, 16'h8000, 16'hFFFF, 16'h0000, 8'd4},
    {1'b1, 1'b0, 5'h15, 5'h00, 16'h000A, 16'h0000, 16'h0000, 8'd1}
  };

  int checks = 0, fails = 0, cyc = 0;
  int rcnt = 0, done_cnt = 0;
  logic cap_o [140];
  logic cap_oe [140];
  realtime trise [2];
  logic g_ext = 1'b0, g_wr = 1'b1, g_ta_bad = 1'b0;
  logic [15:0] g_rd = '0;

  function automatic logic resp(int n);
    int base, pos;
    base = g_ext ? 65 : 0;
    pos  = n - base;
    if (g_wr || pos < 0) return 1'b1;
    if (pos == 47) return g_ta_bad;
    if (pos >= 48 && pos <= 63) return g_rd[63 - pos];
    return 1'b1;
  endfunction

  assign mdio_i = resp(rcnt);

  always @(posedge mdc) begin
    if (rcnt < 140) begin
      cap_o[rcnt]  <= mdio_o;
      cap_oe[rcnt] <= mdio_oe;
    end
    if (rcnt < 2) trise[rcnt] <= $realtime;
    rcnt <= rcnt + 1;
  end

  always @(negedge clk) if (done) done_cnt = done_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected {oe, value} of bit i of the whole access
  function automatic logic [1:0] exp_at(int i, logic wr, logic ext, logic [4:0] port,
                                        logic [4:0] fld, logic [15:0] off, logic [15:0] wd);
    logic adr, rd;
    logic [1:0] op;
    logic [15:0] dat;
    int p;
    adr = ext && i < 65;
    p   = (ext && !adr) ? i - 65 : i;
    rd  = !wr && !adr;
    op  = adr ? 2'b00 : (wr ? 2'b01 : (ext ? 2'b11 : 2'b10));
    dat = adr ? off : wd;
    if (p < 32)  return 2'b11;
    if (p == 32) return 2'b10;
    if (p == 33) return {1'b1, !ext};
    if (p == 34) return {1'b1, op[1]};
    if (p == 35) return {1'b1, op[0]};
    if (p < 41)  return {1'b1, port[40 - p]};
    if (p < 46)  return {1'b1, fld[45 - p]};
    if (p == 46) return rd ? 2'b00 : 2'b11;
    if (p == 47) return rd ? 2'b00 : 2'b10;
    if (p < 64)  return rd ? 2'b00 : {1'b1, dat[63 - p]};
    return 2'b00;
  endfunction

  task automatic run(input logic [67:0] v, input bit ta_bad, input bit inject);
    logic wr, ext;
    logic [4:0] port, dev, fld;
    logic [15:0] off, wd, rdv;
    int hv, nexp, bad;
    logic [1:0] e;
    string tag;
    wr = v[67]; ext = v[66]; port = v[65:61]; dev = v[60:56];
    off = v[55:40]; wd = v[39:24]; rdv = v[23:8];
    hv = (v[7:0] == 0) ? 1 : int'(v[7:0]);
    fld  = ext ? dev : off[4:0];
    nexp = (ext ? 65 : 0) + (wr ? 64 : 65);
    tag  = ext ? "R5" : (wr ? "R6" : "R7");
    @(negedge clk);
    g_ext = ext; g_wr = wr; g_rd = rdv; g_ta_bad = ta_bad;
    rcnt = 0; done_cnt = 0;
    req_write = wr; req_port = port; mdc_half = v[7:0]; req_wdata = wd;
    req_addr = ext ? {1'b1, 10'd0, dev, off} : {27'd0, off[4:0]};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R9", "busy after accept", {31'd0, busy}, 32'd1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req_write = ~wr; req_port = ~port; req_addr = ~req_addr; req_wdata = ~wd;
      mdc_half = 8'd7; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == 0 && cyc < 150000) @(negedge clk);
    repeat (4 * hv + 4) @(negedge clk);
    bad = -1;
    for (int i = 0; i < nexp; i++) begin
      e = exp_at(i, wr, ext, port, fld, off, wd);
      if (bad < 0 && (cap_oe[i] !== e[1] || (e[1] && cap_o[i] !== e[0]))) bad = i;
    end
    if (bad >= 0) begin
      e = exp_at(bad, wr, ext, port, fld, off, wd);
      check(1'b0, bad < 32 ? "R3" : (ext ? "R5" : "R4"), $sformatf("frame bit %0d {oe,o}", bad),
            {30'd0, cap_oe[bad], cap_o[bad]}, {30'd0, e});
    end else check(1'b1, tag, "frame", 0, 0);
    check(rcnt == nexp, tag, "mdc cycle count", rcnt, nexp);
    check(int'((trise[1] - trise[0]) / 8.0) == 2 * hv, "R2", "mdc period in clocks",
          int'((trise[1] - trise[0]) / 8.0), 2 * hv);
    check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    if (!wr) check(rd_data === rdv, "R7", "read data", {16'd0, rd_data}, {16'd0, rdv});
    check(rd_err === ta_bad, "R8", "turnaround error", {31'd0, rd_err}, {31'd0, ta_bad});
    check(busy === 1'b0 && mdio_oe === 1'b0 && mdc === 1'b0, "R10", "idle pins after access",
          {29'd0, busy, mdio_oe, mdc}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1",
          "outputs in reset", {28'd0, busy, done, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1",
          "outputs idle after reset", {29'd0, busy, mdc, mdio_oe}, 0);

    for (int k = 0; k < NV; k++) run(VEC[k], 1'b0, 1'b0);

    // R8: PHY leaves second turnaround bit high, legacy and extended
    run(VEC[1], 1'b1, 1'b0);
    run(VEC[3], 1'b1, 1'b0);
    // R8: a following good write clears the flag
    run(VEC[0], 1'b0, 1'b0);
    // R9: requests while busy ignored, legacy read and extended write
    run(VEC[1], 1'b0, 1'b1);
    run(VEC[2], 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule